// File: doc/BRIEF.md
# TDM Highway Transmit Serializer

The block turns per-time-slot bytes into a serial bit stream on a pair of time-division transmit highways. It runs on a fast system clock. It samples the highway bit clock as a synchronous input and launches one bit on each selected edge of that clock, the rising edge or the falling edge as configured. A frame-sync pulse that is seen on a launch edge restarts the frame position. The first bit of slot 0 then follows after a programmable delay. That delay has a coarse part in whole bytes and a fine part in bit times.

There are 32 slots in each frame. Each slot has its own bit in an enable mask and its own bit in a route mask. The enable bit decides whether anything is driven during the slot. The route bit picks the primary highway A or the secondary highway B. In normal mode a slot is 8 bits long. In associated-signaling mode a slot is 16 bits long: its data byte and then its signaling byte, so the frame is twice as long. Slot contents come from an external frame buffer over a combinational read port addressed by slot index. Every output pair is a data bit plus a drive-enable, and the pad ring builds the tri-state driver from them.

Top module: `tdm_hwy_tx`

## Requirements
- R1: While reset is held, and after it until the first frame sync, all four highway outputs (both data bits and both enables) are 0.
- R2: Outputs change only in the system-clock cycle after a launch edge of the highway clock. With cfg_launch_rise_i=1 the rising edge is the launch edge, and with 0 the falling edge is. The other edge has no effect.
- R3: Launch edges are numbered from the edge on which frame_sync_i is high, which is number 0. Frame bit 0, the MSB of slot 0, is launched on edge number 8*byte offset + bit offset.
- R4: The byte offset covers 0 to 127 and the bit offset covers 0 to 7. Both extremes are honoured, giving a total delay of 0 to 1023 bit times.
- R5: In normal mode (cfg_sig_mode_i=0), slot s occupies frame bits 8s to 8s+7 and is sent MSB first from buf_data_i. The frame is 256 bits long.
- R6: In associated-signaling mode (cfg_sig_mode_i=1), slot s occupies frame bits 16s to 16s+15. The first 8 bits are buf_data_i MSB first and the next 8 are buf_sig_i MSB first. The frame is 512 bits long.
- R7: When enable-mask bit s is 0, both drive-enables are 0 and both data bits are 0 for the whole of slot s.
- R8: For an enabled slot, route-mask bit 0 drives the slot on highway A and bit 1 drives it on highway B. The highway that is not chosen has its enable and data at 0, so the two enables are never high together.
- R9: Outside the frame window (before frame bit 0, and after the last frame bit until the next sync), both highways are released.
- R10: A frame sync that arrives in the middle of a frame restarts the position count at once, using the offsets in force at that moment.
- R11: buf_slot_o presents the index of the slot that holds the bit being launched, so the buffer read returns that slot's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_clk_i | input | 1 | Highway bit clock, synchronous to clk |
| frame_sync_i | input | 1 | Frame-sync pulse, sampled on launch edges |
| cfg_launch_rise_i | input | 1 | 1: launch on rising edge, 0: on falling edge |
| cfg_sig_mode_i | input | 1 | 1: 16-bit slots with signaling byte |
| cfg_byte_off_i | input | 7 | Frame start delay in bytes |
| cfg_bit_off_i | input | 3 | Frame start delay in bit times |
| cfg_slot_en_i | input | 32 | Per-slot drive enable |
| cfg_hwy_sel_i | input | 32 | Per-slot route: 0 = A, 1 = B |
| buf_slot_o | output | 5 | Slot index for the frame-buffer read |
| buf_data_i | input | 8 | Data byte of the addressed slot |
| buf_sig_i | input | 8 | Signaling byte of the addressed slot |
| hwy_a_o | output | 1 | Highway A data |
| hwy_a_oe_o | output | 1 | Highway A drive-enable |
| hwy_b_o | output | 1 | Highway B data |
| hwy_b_oe_o | output | 1 | Highway B drive-enable |

## Verification
The bench builds the block with its default parameters: 32 slots and a 7-bit byte offset. This puts the full 1023-bit start delay within reach, and so is the 512-bit signaling-mode frame that follows it, which drives the position counter to its widest value. Runs cover both launch edges, offsets of zero and of the maximum, a mid-frame resync, and mask patterns that mix enabled and released slots on both highways. Because every slot's bytes differ, a slot-indexing error is visible on the line.

// File: rtl/tdm_tx_pkg.sv
// Shared constants and helpers for the TDM highway transmit serializer.
// Assumes 8-bit bytes, so the fine offset is always 3 bits wide.
package tdm_tx_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_OFF_W = 3;

    // One launched highway state: data and enable for both outputs.
    typedef struct packed {
        logic a_d;
        logic a_oe;
        logic b_d;
        logic b_oe;
    } hwy_pins_t;

    // Selects the serial bit for a position within a slot, MSB first per byte.
    function automatic logic slot_bit(input logic [3:0] pos,
                                      input logic [BYTE_W-1:0] data,
                                      input logic [BYTE_W-1:0] sig);
        logic [2:0] idx;
        idx = 3'd7 - pos[2:0];
        return pos[3] ? sig[idx] : data[idx];
    endfunction
endpackage

// File: rtl/tdm_edge_sel.sv
// Launch-edge detector: produces a one-cycle tick on the chosen edge of the
// highway bit clock. Assumes hw_clk_i is already synchronous to clk and that
// each of its phases lasts at least one clk cycle.
module tdm_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_clk_i,
    input  logic rise_sel_i,
    output logic tick_o
);
    logic hw_q;

    // Keeps last cycle's highway clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= 1'b0;
        else        hw_q <= hw_clk_i;
    end

    // Picks the rising or falling transition as the launch tick.
    always_comb begin
        if (rise_sel_i) tick_o = hw_clk_i & ~hw_q;
        else            tick_o = ~hw_clk_i & hw_q;
    end
endmodule

// File: rtl/tdm_frame_timer.sv
// Frame position timer: counts launch ticks since the last frame sync and
// maps the current tick to a frame bit, slot index and in-slot bit position.
// Assumes the counter is wide enough to hold maximum offset plus longest
// frame; it saturates so the idle state persists until the next sync.
module tdm_frame_timer #(
    parameter int NUM_SLOTS  = 32,
    parameter int BYTE_OFF_W = 7,
    parameter int SLOT_W     = 5,
    parameter int K_W        = 11
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  tick_i,
    input  logic                                  fsync_i,
    input  logic                                  sig_mode_i,
    input  logic [BYTE_OFF_W-1:0]                 byte_off_i,
    input  logic [tdm_tx_pkg::BIT_OFF_W-1:0]      bit_off_i,
    output logic                                  active_o,
    output logic [SLOT_W-1:0]                     slot_o,
    output logic [3:0]                            bitpos_o
);
    localparam logic [K_W-1:0] K_MAX      = '1;
    localparam logic [K_W-1:0] FLEN_SHORT = K_W'(NUM_SLOTS * 8);
    localparam logic [K_W-1:0] FLEN_LONG  = K_W'(NUM_SLOTS * 16);

    logic [K_W-1:0] k_reg, k_now, start_pos, rel, flen;

    // Tick index for the current launch edge: zero on sync, else saturating increment.
    always_comb begin
        if (fsync_i)             k_now = '0;
        else if (k_reg == K_MAX) k_now = K_MAX;
        else                     k_now = k_reg + 1'b1;
    end

    // Holds the tick index of the last launch edge; idle (saturated) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      k_reg <= K_MAX;
        else if (tick_i) k_reg <= k_now;
    end

    // Maps the tick index to the frame window, slot and bit position.
    always_comb begin
        start_pos = K_W'({byte_off_i, bit_off_i});
        flen      = sig_mode_i ? FLEN_LONG : FLEN_SHORT;
        rel       = k_now - start_pos;
        active_o  = (k_now >= start_pos) && (rel < flen);
        if (sig_mode_i) begin
            slot_o   = rel[SLOT_W+3:4];
            bitpos_o = rel[3:0];
        end else begin
            slot_o   = rel[SLOT_W+2:3];
            bitpos_o = {1'b0, rel[2:0]};
        end
    end

    // A sync with zero offsets must launch slot 0's MSB on the same edge.
    assert_zero_offset_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && fsync_i && byte_off_i == '0 && bit_off_i == '0)
        |-> (active_o && slot_o == '0 && bitpos_o == 4'd0));
endmodule

// File: rtl/tdm_slot_driver.sv
// Slot driver: on each launch tick, picks the serial bit of the addressed
// slot, applies the per-slot enable and route masks and registers the
// highway pins. Assumes buf data is valid combinationally for slot_i.
module tdm_slot_driver #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          active_i,
    input  logic [SLOT_W-1:0]             slot_i,
    input  logic [3:0]                    bitpos_i,
    input  logic [NUM_SLOTS-1:0]          slot_en_i,
    input  logic [NUM_SLOTS-1:0]          hwy_sel_i,
    input  logic [tdm_tx_pkg::BYTE_W-1:0] data_i,
    input  logic [tdm_tx_pkg::BYTE_W-1:0] sig_i,
    output tdm_tx_pkg::hwy_pins_t         pins_o
);
    import tdm_tx_pkg::*;

    hwy_pins_t pins_next;
    logic      drive, to_b, bit_v;

    // Builds the next pin state from masks and the selected serial bit.
    always_comb begin
        drive          = active_i & slot_en_i[slot_i];
        to_b           = hwy_sel_i[slot_i];
        bit_v          = slot_bit(bitpos_i, data_i, sig_i);
        pins_next.a_oe = drive & ~to_b;
        pins_next.b_oe = drive & to_b;
        pins_next.a_d  = drive & ~to_b & bit_v;
        pins_next.b_d  = drive & to_b & bit_v;
    end

    // Registers the pins only on launch ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      pins_o <= '0;
        else if (tick_i) pins_o <= pins_next;
    end

    // Outside the frame window both highways are released.
    assert_idle_outside_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !active_i) |=> (!pins_o.a_oe && !pins_o.b_oe && !pins_o.a_d && !pins_o.b_d));
    // A masked-off slot drives neither highway.
    assert_masked_slot_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && active_i && !slot_en_i[slot_i]) |=> (!pins_o.a_oe && !pins_o.b_oe));
    // The two highways are never enabled together.
    assert_single_highway_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pins_o.a_oe, pins_o.b_oe}));
endmodule

// File: rtl/tdm_hwy_tx.sv
// TDM highway transmit serializer top: ties launch-edge detection, frame
// position timing and slot driving together. Assumes hw_clk_i and
// frame_sync_i are synchronous to clk and that offsets suit the highway rate.
module tdm_hwy_tx #(
    parameter int NUM_SLOTS  = 32,
    parameter int BYTE_OFF_W = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hw_clk_i,
    input  logic                                  frame_sync_i,
    input  logic                                  cfg_launch_rise_i,
    input  logic                                  cfg_sig_mode_i,
    input  logic [BYTE_OFF_W-1:0]                 cfg_byte_off_i,
    input  logic [tdm_tx_pkg::BIT_OFF_W-1:0]      cfg_bit_off_i,
    input  logic [NUM_SLOTS-1:0]                  cfg_slot_en_i,
    input  logic [NUM_SLOTS-1:0]                  cfg_hwy_sel_i,
    output logic [$clog2(NUM_SLOTS)-1:0]          buf_slot_o,
    input  logic [tdm_tx_pkg::BYTE_W-1:0]         buf_data_i,
    input  logic [tdm_tx_pkg::BYTE_W-1:0]         buf_sig_i,
    output logic                                  hwy_a_o,
    output logic                                  hwy_a_oe_o,
    output logic                                  hwy_b_o,
    output logic                                  hwy_b_oe_o
);
    import tdm_tx_pkg::*;

    localparam int SLOT_W   = $clog2(NUM_SLOTS);
    localparam int OFF_MAX  = (2**(BYTE_OFF_W + BIT_OFF_W)) - 1;
    localparam int FLEN_MAX = NUM_SLOTS * 16;
    localparam int K_W      = $clog2(OFF_MAX + FLEN_MAX + 1);

    logic              tick;
    logic              active;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        bitpos;
    hwy_pins_t         pins;

    tdm_edge_sel u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_clk_i   (hw_clk_i),
        .rise_sel_i (cfg_launch_rise_i),
        .tick_o     (tick)
    );

    tdm_frame_timer #(
        .NUM_SLOTS  (NUM_SLOTS),
        .BYTE_OFF_W (BYTE_OFF_W),
        .SLOT_W     (SLOT_W),
        .K_W        (K_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .fsync_i    (frame_sync_i),
        .sig_mode_i (cfg_sig_mode_i),
        .byte_off_i (cfg_byte_off_i),
        .bit_off_i  (cfg_bit_off_i),
        .active_o   (active),
        .slot_o     (slot),
        .bitpos_o   (bitpos)
    );

    tdm_slot_driver #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .active_i  (active),
        .slot_i    (slot),
        .bitpos_i  (bitpos),
        .slot_en_i (cfg_slot_en_i),
        .hwy_sel_i (cfg_hwy_sel_i),
        .data_i    (buf_data_i),
        .sig_i     (buf_sig_i),
        .pins_o    (pins)
    );

    // Exposes the slot address and the registered highway pins.
    always_comb begin
        buf_slot_o = slot;
        hwy_a_o    = pins.a_d;
        hwy_a_oe_o = pins.a_oe;
        hwy_b_o    = pins.b_d;
        hwy_b_oe_o = pins.b_oe;
    end

    // Pins hold still unless a launch edge was seen in the previous cycle.
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({hwy_a_o, hwy_a_oe_o, hwy_b_o, hwy_b_oe_o}));
endmodule

// File: tb/tb_tdm_hwy_tx.sv
// Scoreboard bench: the driver task launches highway-clock edges and queues
// the expected pin state; the monitor compares one cycle after each launch.
module tb_tdm_hwy_tx;
    typedef struct packed {
        logic ad;
        logic aoe;
        logic bd;
        logic boe;
    } pins_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_clk = 1'b0;
    logic        fsync = 1'b0;
    logic        rise = 1'b1;
    logic        sig_mode = 1'b0;
    logic [6:0]  byte_off = '0;
    logic [2:0]  bit_off = '0;
    logic [31:0] slot_en = '0;
    logic [31:0] hwy_sel = '0;
    logic [4:0]  buf_slot;
    logic [7:0]  buf_data, buf_sig;
    logic        a_d, a_oe, b_d, b_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    k_model = 2047;
    pins_t exp_q[$];
    string tag_q[$];
    event  launched;

    always #2 clk = ~clk;

    function automatic logic [7:0] data_of(input int s);
        return 8'((s * 37 + 11) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] sig_of(input int s);
        return 8'((s * 13) ^ 8'hC3);
    endfunction

    // Frame buffer model, read combinationally by slot index (R11).
    assign buf_data = data_of(int'(buf_slot));
    assign buf_sig  = sig_of(int'(buf_slot));

    tdm_hwy_tx dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .hw_clk_i          (hw_clk),
        .frame_sync_i      (fsync),
        .cfg_launch_rise_i (rise),
        .cfg_sig_mode_i    (sig_mode),
        .cfg_byte_off_i    (byte_off),
        .cfg_bit_off_i     (bit_off),
        .cfg_slot_en_i     (slot_en),
        .cfg_hwy_sel_i     (hwy_sel),
        .buf_slot_o        (buf_slot),
        .buf_data_i        (buf_data),
        .buf_sig_i         (buf_sig),
        .hwy_a_o           (a_d),
        .hwy_a_oe_o        (a_oe),
        .hwy_b_o           (b_d),
        .hwy_b_oe_o        (b_oe)
    );

    // Expected pins for one launch edge, from R3..R9 and R10.
    task automatic push_expect(input logic fs);
        pins_t e;
        int off, flen, b, s, j;
        logic bv;
        if (fs) k_model = 0;
        else if (k_model < 2047) k_model++;
        off  = int'(byte_off) * 8 + int'(bit_off);
        flen = sig_mode ? 512 : 256;
        e    = '0;
        if (k_model >= off && k_model - off < flen) begin
            b  = k_model - off;
            s  = sig_mode ? b / 16 : b / 8;
            j  = sig_mode ? b % 16 : b % 8;
            bv = (j < 8) ? data_of(s)[7 - j] : sig_of(s)[15 - j];
            if (slot_en[s]) begin
                if (hwy_sel[s]) begin e.boe = 1'b1; e.bd = bv; end
                else            begin e.aoe = 1'b1; e.ad = bv; end
            end
            tag_q.push_back(sig_mode ? "R6 R7 R8 R11" : "R5 R7 R8 R11");
        end else begin
            tag_q.push_back("R9");
        end
        exp_q.push_back(e);
    endtask

    // One full highway-clock period; the launch edge carries the sync flag (R2).
    task automatic hw_period(input logic fs);
        if (rise) begin
            @(negedge clk); hw_clk = 1'b1; fsync = fs; push_expect(fs); -> launched;
            @(negedge clk); fsync = 1'b0;
            @(negedge clk); hw_clk = 1'b0;
            @(negedge clk);
        end else begin
            @(negedge clk); hw_clk = 1'b1;
            @(negedge clk);
            @(negedge clk); hw_clk = 1'b0; fsync = fs; push_expect(fs); -> launched;
            @(negedge clk); fsync = 1'b0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) hw_period(1'b0);
    endtask

    // Monitor: compares one cycle after each launch edge.
    initial begin
        forever begin
            pins_t e;
            string t;
            @(launched);
            @(negedge clk);
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: output seen with no expectation queued, got %b%b%b%b expected none",
                         a_d, a_oe, b_d, b_oe);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({a_d, a_oe, b_d, b_oe} !== e) begin
                    n_bad++;
                    $display("FAIL %s (k=%0d): got a=%b/%b b=%b/%b expected a=%b/%b b=%b/%b",
                             t, k_model, a_d, a_oe, b_d, b_oe, e.ad, e.aoe, e.bd, e.boe);
                end
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs low during and after reset.
        repeat (5) @(negedge clk);
        n_cmp++;
        if ({a_d, a_oe, b_d, b_oe} !== 4'b0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 0000", {a_d, a_oe, b_d, b_oe});
        end
        rst_n = 1'b1;
        slot_en = 32'hF0F0_A5C3;
        hwy_sel = 32'h3C3C_9966;
        // R1/R9: no sync yet, so highways stay released.
        run(20);

        // R5, R3, R4: rising launch, zero offsets, normal frame plus idle tail.
        rise = 1'b1; sig_mode = 1'b0; byte_off = 7'd0; bit_off = 3'd0;
        hw_period(1'b1);
        run(265);

        // R2, R4: falling launch, offsets 31 bytes + 7 bits.
        rise = 1'b0; byte_off = 7'd31; bit_off = 3'd7;
        slot_en = 32'h7FFF_FFFE; hwy_sel = 32'hAAAA_5555;
        hw_period(1'b1);
        run(520);

        // R6, R4: rising launch, signaling mode, maximum offsets 127 + 7.
        rise = 1'b1; sig_mode = 1'b1; byte_off = 7'd127; bit_off = 3'd7;
        slot_en = 32'hFFFF_FFFF; hwy_sel = 32'h0F0F_F0F0;
        hw_period(1'b1);
        run(1540);

        // R10: resync mid-frame with small offsets.
        sig_mode = 1'b0; byte_off = 7'd2; bit_off = 3'd3;
        slot_en = 32'h0FF0_33CC; hwy_sel = 32'h5A5A_A5A5;
        hw_period(1'b1);
        run(100);
        hw_period(1'b1);
        run(300);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: got %0d pending expectations expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule